// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Station Address Autoload

This block is the master for a three-wire serial EEPROM. On each request it sends a read command and then clocks in one 16-bit word, most significant bit first. A strap input gives the device size. When the strap is low the command carries 6 address bits, and when it is high the command carries 8 address bits. The serial clock half-period is set in system clocks by a divider input.

After reset an autoload sequencer takes control of the serial engine. It reads word 0 and checks it against a fixed signature. If the signature matches, it reads words 7, 8 and 9 and builds a 48-bit station address from them. The address is committed only if it is a valid individual address. While the sequencer is active, host requests are blocked. Once it finishes, the host can read any word with a one-cycle start request and receives a done pulse when the data is ready.

Top module: `ee_word_fetch`

## Requirements
- R1: With the strap low, a read sends a 9-bit command on the data line, most significant bit first: the opcode 3'b110 and then the 6-bit word address (address bits 5:0). The transaction has 25 serial clock rising edges in total.
- R2: With the strap high, the command is 11 bits: the opcode 3'b110 and then the 8-bit word address. The transaction has 27 rising edges in total.
- R3: Chip select rises before the first command bit and stays high until the last data bit has been sampled. The serial clock stays low whenever chip select is low.
- R4: The data line to the device changes only while the serial clock is low.
- R5: Sixteen data bits are taken from the device's data output, most significant bit first. Each bit is sampled at the end of a clock-high half-period. The resulting word appears on `data_o` while `done_o` is high.
- R6: A half-period lasts max(`half_div_i`, 2) system clocks. `done_o` rises (2N+33) half-periods after the clock edge that accepts a start, where N is the command length.
- R7: Between consecutive words, chip select stays low for at least one half-period.
- R8: `done_o` is a single-cycle pulse for each completed word. A start request that arrives while `busy_o` is high is ignored and causes no extra transaction.
- R9: After reset the autoload sequencer reads word 0. If that word differs from 16'h8129, it sets `sig_miss_o`, reads nothing further, and leaves `station_o` at zero with `station_vld_o` low.
- R10: If the signature matches, the sequencer reads words 7, 8 and 9. Word 7+k fills `station_o[16k+15:16k]`, so the low byte of each word becomes the lower-numbered address byte. On success `station_vld_o` is set.
- R11: If bit 0 of `station_o` would be 1, or the whole address is zero, the sequencer sets `addr_bad_o`, does not commit the address, and leaves `station_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_div_i | input | DIV_W | Serial clock half-period in system clocks (values below 2 act as 2) |
| big_dev_i | input | 1 | Device-size strap: 0 selects a 6-bit address, 1 selects an 8-bit address |
| start_i | input | 1 | Host read request |
| addr_i | input | 8 | Host word address |
| busy_o | output | 1 | A read or the autoload sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a word read completes |
| data_o | output | 16 | Last word read |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |
| sig_miss_o | output | 1 | Signature word did not match |
| addr_bad_o | output | 1 | Station address was rejected as invalid |
| station_o | output | 48 | Committed station address |
| station_vld_o | output | 1 | Station address was committed |

## Verification
Suppose the bit counter or the phase flag in the serial engine holds a wrong value. The bench model then receives a command of the wrong length or a different address within the same word, and the data returned in that same transaction does not match. The done latency also moves by a whole number of half-periods. If the autoload state is wrong, the error shows up once autoload completes: the device sees the wrong number of word reads, or the address, valid flag or error flags do not match the expected values.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int          WORD_W   = 16;
  localparam int          ADDR_W   = 8;
  localparam int          SADDR_W  = 6;
  localparam int          OP_W     = 3;
  localparam int          CMD_W    = OP_W + ADDR_W;
  localparam int          BIT_W    = $clog2(WORD_W);
  localparam logic [OP_W-1:0]   READ_OP  = 3'b110;
  localparam logic [WORD_W-1:0] SIG_WORD = 16'h8129;
  localparam logic [ADDR_W-1:0] MAC_BASE = 8'd7;
  localparam int          MAC_WORDS = 3;
  localparam int          MAC_W    = MAC_WORDS * WORD_W;

  typedef enum logic [1:0] {ENG_IDLE, ENG_CMD, ENG_DAT, ENG_GAP} eng_state_e;
  typedef enum logic [2:0] {B_SIG_REQ, B_SIG_WAIT, B_W_REQ, B_W_WAIT, B_CHECK, B_END} boot_state_e;
endpackage

// File: rtl/ee_tick_gen.sv
module ee_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] eff, cnt_q;

  assign eff = (half_i < MIN_HALF) ? MIN_HALF : half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || cnt_q == '0)  cnt_q <= eff - DIV_W'(1);
    else                                cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == '0) && !restart_i;
endmodule

// File: rtl/ee_mw_engine.sv
module ee_mw_engine
  import ee_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_i,
  input  logic              tick_i,
  input  logic              do_i,
  output logic              restart_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o
);
  eng_state_e        st_q;
  logic              ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] shf_q;
  logic              cs_q, sk_q, di_q, done_q;

  assign restart_o = (st_q == ENG_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENG_IDLE;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      cmd_q  <= '0;
      shf_q  <= '0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      di_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ENG_IDLE: if (req_i) begin
          // short device: left-align 9-bit command in the 11-bit shifter
          cmd_q <= big_i ? {READ_OP, addr_i} : {READ_OP, addr_i[SADDR_W-1:0], 2'b00};
          bit_q <= big_i ? BIT_W'(CMD_W - 1) : BIT_W'(OP_W + SADDR_W - 1);
          cs_q  <= 1'b1;
          sk_q  <= 1'b0;
          di_q  <= READ_OP[OP_W-1];
          ph_q  <= 1'b0;
          st_q  <= ENG_CMD;
        end
        ENG_CMD: if (tick_i) begin
          if (!ph_q) begin
            sk_q <= 1'b1;
            ph_q <= 1'b1;
          end else begin
            sk_q <= 1'b0;
            ph_q <= 1'b0;
            if (bit_q == '0) begin
              st_q  <= ENG_DAT;
              bit_q <= BIT_W'(WORD_W - 1);
              di_q  <= 1'b0;
            end else begin
              bit_q <= bit_q - BIT_W'(1);
              cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
              di_q  <= cmd_q[CMD_W-2];
            end
          end
        end
        ENG_DAT: if (tick_i) begin
          if (!ph_q) begin
            sk_q <= 1'b1;
            ph_q <= 1'b1;
          end else begin
            sk_q  <= 1'b0;
            ph_q  <= 1'b0;
            shf_q <= {shf_q[WORD_W-2:0], do_i};
            if (bit_q == '0) begin
              st_q <= ENG_GAP;
              cs_q <= 1'b0;
            end else begin
              bit_q <= bit_q - BIT_W'(1);
            end
          end
        end
        ENG_GAP: if (tick_i) begin
          st_q   <= ENG_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ENG_IDLE);
  assign done_o = done_q;
  assign word_o = shf_q;
  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = di_q;
endmodule

// File: rtl/ee_boot_seq.sv
module ee_boot_seq
  import ee_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic              sig_miss_o,
  output logic              addr_bad_o,
  output logic [MAC_W-1:0]  station_o,
  output logic              station_vld_o
);
  localparam int IDX_W = $clog2(MAC_WORDS);

  boot_state_e      st_q;
  logic [IDX_W-1:0] idx_q;
  logic [MAC_W-1:0] buf_q, station_q;
  logic             miss_q, bad_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= B_SIG_REQ;
      idx_q     <= '0;
      buf_q     <= '0;
      station_q <= '0;
      miss_q    <= 1'b0;
      bad_q     <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      unique case (st_q)
        B_SIG_REQ: st_q <= B_SIG_WAIT;
        B_SIG_WAIT: if (done_i) begin
          if (word_i == SIG_WORD) begin
            idx_q <= '0;
            st_q  <= B_W_REQ;
          end else begin
            miss_q <= 1'b1;
            st_q   <= B_END;
          end
        end
        B_W_REQ: st_q <= B_W_WAIT;
        B_W_WAIT: if (done_i) begin
          for (int k = 0; k < MAC_WORDS; k++)
            if (idx_q == IDX_W'(k)) buf_q[k*WORD_W +: WORD_W] <= word_i;
          if (idx_q == IDX_W'(MAC_WORDS - 1)) st_q <= B_CHECK;
          else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= B_W_REQ;
          end
        end
        B_CHECK: begin
          if (!buf_q[0] && buf_q != '0) begin
            station_q <= buf_q;
            vld_q     <= 1'b1;
          end else begin
            bad_q <= 1'b1;
          end
          st_q <= B_END;
        end
        B_END:   st_q <= B_END;
        default: st_q <= B_END;
      endcase
    end
  end

  assign req_o         = (st_q == B_SIG_REQ) || (st_q == B_W_REQ);
  assign addr_o        = (st_q == B_SIG_REQ) ? '0 : MAC_BASE + ADDR_W'(idx_q);
  assign active_o      = (st_q != B_END);
  assign sig_miss_o    = miss_q;
  assign addr_bad_o    = bad_q;
  assign station_o     = station_q;
  assign station_vld_o = vld_q;
endmodule

// File: rtl/ee_word_fetch.sv
module ee_word_fetch
  import ee_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              big_dev_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i,
  output logic              sig_miss_o,
  output logic              addr_bad_o,
  output logic [MAC_W-1:0]  station_o,
  output logic              station_vld_o
);
  logic              tick, restart, eng_busy, eng_req, eng_done;
  logic              boot_req, boot_active;
  logic [ADDR_W-1:0] boot_addr, eng_addr;
  logic [WORD_W-1:0] eng_word;

  assign eng_req  = boot_active ? boot_req  : start_i;
  assign eng_addr = boot_active ? boot_addr : addr_i;

  ee_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .restart_i(restart), .half_i(half_div_i), .tick_o(tick)
  );

  ee_mw_engine i_eng (
    .clk_i, .rst_ni, .req_i(eng_req), .addr_i(eng_addr), .big_i(big_dev_i),
    .tick_i(tick), .do_i, .restart_o(restart), .busy_o(eng_busy),
    .done_o(eng_done), .word_o(eng_word), .cs_o, .sk_o, .di_o
  );

  ee_boot_seq i_boot (
    .clk_i, .rst_ni, .done_i(eng_done), .word_i(eng_word), .req_o(boot_req),
    .addr_o(boot_addr), .active_o(boot_active), .sig_miss_o, .addr_bad_o,
    .station_o, .station_vld_o
  );

  assign busy_o = eng_busy | boot_active;
  assign done_o = eng_done;
  assign data_o = eng_word;
endmodule

// File: rtl/ee_word_fetch_chk.sv
module ee_word_fetch_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DIV_W-1:0] half_div_i,
  input logic             cs_o,
  input logic             sk_o,
  input logic             di_o,
  input logic             done_o,
  input logic             sig_miss_o,
  input logic [47:0]      station_o,
  input logic             station_vld_o
);
  logic [DIV_W:0]   gap_q;
  logic             armed_q;
  logic [DIV_W-1:0] min_half;

  assign min_half = (half_div_i < DIV_W'(2)) ? DIV_W'(2) : half_div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_q | cs_o;
      if (cs_o)               gap_q <= '0;
      else if (!(&gap_q))     gap_q <= gap_q + 1'b1;
    end
  end

  assert_sk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);

  assert_di_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));

  assert_cs_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_o) && armed_q) |-> (gap_q >= {1'b0, min_half}));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_sig_nocommit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_miss_o |-> !station_vld_o);

  assert_commit_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(station_vld_o) |-> (!station_o[0] && station_o != '0));
endmodule

bind ee_word_fetch ee_word_fetch_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_div_i(half_div_i), .cs_o(cs_o),
  .sk_o(sk_o), .di_o(di_o), .done_o(done_o), .sig_miss_o(sig_miss_o),
  .station_o(station_o), .station_vld_o(station_vld_o)
);

// File: tb/test_ee_word_fetch.sv
`timescale 1ns/1ps
module test_ee_word_fetch;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  half_div = 8'd3;
  logic        big = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  addr = '0;
  logic        busy, done, cs, sk, di, sig_miss, addr_bad, st_vld;
  logic        do_r = 1'b0;
  logic [15:0] data;
  logic [47:0] station;

  logic [15:0] sig_w = 16'h8129, w7 = '0, w8 = '0, w9 = '0;

  int tests = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ee_word_fetch i_ee_word_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .half_div_i(half_div), .big_dev_i(big),
    .start_i(start), .addr_i(addr), .busy_o(busy), .done_o(done), .data_o(data),
    .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_r), .sig_miss_o(sig_miss),
    .addr_bad_o(addr_bad), .station_o(station), .station_vld_o(st_vld)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    case (a)
      8'd0:    return sig_w;
      8'd7:    return w7;
      8'd8:    return w8;
      8'd9:    return w9;
      default: return {~a, a ^ 8'hA5};
    endcase
  endfunction

  // EEPROM model
  int          ecnt = 0, last_edges = 0, words_cnt = 0;
  logic [10:0] cmdr = '0, last_cmd = '0;
  int          ncmd;
  logic [7:0]  maddr;
  assign ncmd  = big ? 11 : 9;
  assign maddr = big ? cmdr[7:0] : {2'b00, cmdr[5:0]};

  always @(posedge sk or negedge cs) begin
    if (!cs) begin
      if (ecnt != 0) begin
        last_edges <= ecnt;
        last_cmd   <= cmdr;
        words_cnt  <= words_cnt + 1;
      end
      ecnt <= 0;
      cmdr <= '0;
    end else begin
      logic [15:0] w;
      w = mem_word(maddr);
      if (ecnt < ncmd) cmdr <= {cmdr[9:0], di};
      else if (ecnt - ncmd < 16) do_r <= w[15 - (ecnt - ncmd)];
      ecnt <= ecnt + 1;
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) begin ok = 1; break; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic boot(input logic [15:0] s, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] c, input bool_poke, input bit exp_miss,
                      input bit exp_bad, input int exp_words);
    bit ok;
    int w0;
    logic [47:0] exp_st;
    sig_w = s; w7 = a; w8 = b; w9 = c;
    half_div = 8'd3; big = 1'b0;
    do_reset();
    w0 = words_cnt;
    if (bool_poke) begin
      repeat (40) @(negedge clk);
      addr = 8'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle(ok);
    chk(ok, "R9 autoload finished", ok, 1);
    repeat (6) @(negedge clk);
    exp_st = (exp_miss || exp_bad) ? 48'h0 : {c, b, a};
    chk(sig_miss == exp_miss, "R9 sig_miss", sig_miss, exp_miss);
    chk(addr_bad == exp_bad, "R11 addr_bad", addr_bad, exp_bad);
    chk(st_vld == !(exp_miss || exp_bad), "R10 station_vld", st_vld, !(exp_miss || exp_bad));
    chk(station == exp_st, "R10 station value", station, exp_st);
    chk(words_cnt - w0 == exp_words, "R8 R9 word reads in autoload", words_cnt - w0, exp_words);
  endtask

  task automatic host_read(input logic [7:0] a, input logic [7:0] h, input bit bg, input bit poke);
    int cyc, d0, w0, n, hh;
    logic [7:0] ea;
    logic [15:0] got;
    @(negedge clk);
    half_div = h; big = bg; addr = a; start = 1'b1;
    d0 = done_cnt; w0 = words_cnt;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      cyc++;
      if (poke && cyc == 20) begin
        @(negedge clk);
        addr = a ^ 8'h33; start = 1'b1;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        start = 1'b0;
        if (done) break;
        continue;
      end
      @(negedge clk);
      if (done) break;
    end
    got = data;
    n  = bg ? 11 : 9;
    hh = (h < 2) ? 2 : h;
    ea = bg ? a : {2'b00, a[5:0]};
    chk(got == mem_word(ea), "R5 data word", got, mem_word(ea));
    chk(cyc == (2 * n + 33) * hh, "R6 done latency", cyc, (2 * n + 33) * hh);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
    chk(last_edges == n + 16, bg ? "R2 rising edge count" : "R1 rising edge count", last_edges, n + 16);
    if (bg) begin
      chk(last_cmd[10:8] == 3'b110, "R2 opcode", last_cmd[10:8], 3'b110);
      chk(last_cmd[7:0] == a, "R2 address field", last_cmd[7:0], a);
    end else begin
      chk(last_cmd[8:6] == 3'b110, "R1 opcode", last_cmd[8:6], 3'b110);
      chk(last_cmd[5:0] == a[5:0], "R1 address field", last_cmd[5:0], a[5:0]);
    end
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(done_cnt - d0 == 1, "R8 start while busy ignored (done count)", done_cnt - d0, 1);
      chk(words_cnt - w0 == 1, "R8 start while busy ignored (transactions)", words_cnt - w0, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk(!cs && !sk && !done, "R3 reset outputs idle", {cs, sk, done}, 0);
    chk(station == 0 && !st_vld, "R10 reset station", station, 0);

    // R9 signature mismatch
    boot(16'h8128, 16'h3412, 16'h7856, 16'hBC9A, 1'b0, 1'b1, 1'b0, 1);
    // R11 group bit set in first byte
    boot(16'h8129, 16'h3401, 16'h7856, 16'hBC9A, 1'b0, 1'b0, 1'b1, 4);
    // R11 all-zero address
    boot(16'h8129, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4);
    // R10 good load, host start during autoload ignored (R8)
    boot(16'h8129, 16'h3412, 16'h7856, 16'hBC9A, 1'b1, 1'b0, 1'b0, 4);

    // directed corner cases
    host_read(8'hFF, 8'd2, 1'b1, 1'b0);
    host_read(8'hFF, 8'd2, 1'b0, 1'b0);
    host_read(8'h00, 8'd0, 1'b0, 1'b0);
    host_read(8'h81, 8'd1, 1'b1, 1'b0);
    host_read(8'h07, 8'd4, 1'b0, 1'b1);

    for (int i = 0; i < 24; i++) begin
      host_read(8'($urandom), 8'($urandom % 5), 1'($urandom % 2), 1'b0);
    end
    finish_run();
  end
endmodule